// File: doc/BRIEF.md
# Power-Down Clock Gating Sequencer

This block sits between free-running clock sources and the clock pins of a clock-generator core. It brings several output clock groups to a clean stop at a low level when a sleep request arrives, and then turns off the oscillator and the synthesizers. On wake it turns them back on and keeps every output masked until a fixed settling time has passed. The sleep request is an active-low input that is asynchronous to every clock in the block. It is synchronized and then confirmed on rising edges of the CPU-group clock.

Each output group has its own gate. The gate's enable is captured on the falling edge of that group's own clock and then ANDed with the clock, so no output ever shows a short high pulse. The CPU group is gated in the domain where the request is sampled. Every other group resynchronizes the run level on its own falling edges. A per-group enable bit masks a group permanently, whatever the power state. Synthesizer and oscillator enables are modelled as plain level outputs. A timebase-domain sequencer orders them, counts the settling time and raises a ready flag.

Top module: `pwrdn_clk_seq`

## Requirements
- R1: The request `pwrdn_ni` passes through a two-flop synchronizer on `cpu_clk_i`. Sleep is entered only when the synchronized request is low on two consecutive rising edges. A low that spans only one rising edge of `cpu_clk_i` has no effect: `ready_o` stays 1 and all enabled outputs keep toggling.
- R2: The CPU group (index `CPU_GRP`, whose input clock is the same clock as `cpu_clk_i`) is gated in the sampling domain. If the request falls between two rising edges, `grp_clk_o[CPU_GRP]` gives exactly four more rising edges, then goes low at the following falling edge and stays low.
- R3: Every gated output starts and stops only while its input clock is low. No high phase of any `grp_clk_o` bit is shorter than the high phase of its input clock.
- R4: While asleep, every bit of `grp_clk_o`, including the slowest group, is held static low.
- R5: `ready_o` drops as soon as the sequencer starts draining. `osc_en_o` and `pll_en_o` fall only after all gated outputs have stopped low.
- R6: On wake, `osc_en_o` and `pll_en_o` rise together. `ready_o` rises exactly `STAB_CYC` cycles of `tb_clk_i` later. No gated output toggles during that wait, and the enabled outputs toggle once it ends.
- R7: Bit g of `grp_en_i` set to 0 holds `grp_clk_o[g]` low without toggling. Bit g set to 1 lets it run while awake.
- R8: While `rst_ni` is low, all `grp_clk_o` bits, `osc_en_o`, `pll_en_o` and `ready_o` are 0.
- R9: A sleep request that arrives during the settling wait aborts it. The enables drop and `ready_o` never rises. The next wake restarts the full `STAB_CYC` count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | CPU-domain clock on which the request is sampled |
| tb_clk_i | input | 1 | Free-running timebase for sequencing and settling count |
| pwrdn_ni | input | 1 | Asynchronous active-low sleep request |
| grp_clk_i | input | NUM_GRP | Running clock of each output group |
| grp_en_i | input | NUM_GRP | Per-group output enable, 1 = allowed to run |
| grp_clk_o | output | NUM_GRP | Gated group clocks |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | Synthesizer enable |
| ready_o | output | 1 | Settling complete, outputs released |

## Verification
The bench places the request edge just after a falling CPU edge and counts the gated CPU pulses that follow. One pulse too many or too few reveals a missing synchronizer stage, a missing confirm stage or an extra register. A one-cycle request glitch is applied while awake: a design that lacks the second confirming sample would go to sleep and drop `ready_o`. Every high pulse on every output is timed, so a gate that switches on the rising edge shows up as a sliver. The outputs are captured at the instant the enables fall, which catches enables that are cut before the slow reference group has stopped. The settling interval is measured in timebase cycles, both on a clean wake and after a wake aborted by a new request. A counter that is off by one, or one that is not cleared on abort, gives the wrong count.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WARM  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwrdn_req_qual.sv
// CPU-domain request qualification and run level
module pwrdn_req_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic fsm_run_i,
  output logic sleep_o,
  output logic run_o
);
  logic m1_q, m2_q, prev_q;
  logic rs1_q, rs2_q;
  logic sleep_q, sleep_d, run_q;

  always_comb begin
    sleep_d = sleep_q;
    if (!m2_q && !prev_q)      sleep_d = 1'b1;
    else if (m2_q && !rs2_q)   sleep_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q    <= 1'b0;
      m2_q    <= 1'b0;
      prev_q  <= 1'b0;
      rs1_q   <= 1'b0;
      rs2_q   <= 1'b0;
      sleep_q <= 1'b1;
      run_q   <= 1'b0;
    end else begin
      m1_q    <= req_ni;
      m2_q    <= m1_q;
      prev_q  <= m2_q;
      rs1_q   <= fsm_run_i;
      rs2_q   <= rs1_q;
      sleep_q <= sleep_d;
      run_q   <= rs2_q & ~sleep_d;
    end
  end

  assign sleep_o = sleep_q;
  assign run_o   = run_q;

  // R1
  sleep_blocks_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_q |-> !run_q);

  // R1
  sleep_needs_two_lows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_q) |-> !$past(m2_q) && !$past(m2_q, 2));
endmodule

// File: rtl/pwrdn_clk_gate.sv
// Falling-edge enable capture ANDed with the clock
module pwrdn_clk_gate #(
  parameter bit ASYNC_RUN  = 1'b1,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  output logic clk_o,
  output logic on_o
);
  localparam int LAT = ASYNC_RUN ? SYNC_DEPTH + 1 : 1;

  logic on_q;

  if (ASYNC_RUN) begin : g_sync
    logic [SYNC_DEPTH-1:0] sync_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        on_q   <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_DEPTH-2:0], run_i};
        on_q   <= sync_q[SYNC_DEPTH-1] & en_i;
      end
    end
  end else begin : g_direct
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) on_q <= 1'b0;
      else         on_q <= run_i & en_i;
    end
  end

  assign clk_o = clk_i & on_q;
  assign on_o  = on_q;

  // checker: consecutive falling edges with run low
  logic [3:0] low_cnt_q;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_cnt_q <= '0;
    else if (run_i)           low_cnt_q <= '0;
    else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 4'd1;
  end

  // R4
  stop_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_cnt_q >= 4'(LAT)) |-> !on_q);
endmodule

// File: rtl/pwrdn_seq_fsm.sv
// Timebase-domain sequencer: enables, settling count, drain
module pwrdn_seq_fsm
  import pwrdn_seq_pkg::*;
#(
  parameter int NUM_GRP  = 4,
  parameter int STAB_CYC = 43000,
  localparam int CNT_W   = $clog2(STAB_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic [NUM_GRP-1:0] gate_on_i,
  output logic               run_o,
  output logic               osc_en_o,
  output logic               pll_en_o,
  output logic               ready_o
);
  logic               sl1_q, sl2_q;
  logic [NUM_GRP-1:0] ack1_q, ack2_q;
  seq_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sl1_q  <= 1'b1;
      sl2_q  <= 1'b1;
      ack1_q <= '0;
      ack2_q <= '0;
    end else begin
      sl1_q  <= sleep_i;
      sl2_q  <= sl1_q;
      ack1_q <= gate_on_i;
      ack2_q <= ack1_q;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_OFF: if (!sl2_q) begin
        state_d = ST_WARM;
        cnt_d   = '0;
      end
      ST_WARM: begin
        if (sl2_q)                                  state_d = ST_DRAIN;
        else if (cnt_q == CNT_W'(STAB_CYC - 1))     state_d = ST_RUN;
        else                                        cnt_d   = cnt_q + 1'b1;
      end
      ST_RUN:   if (sl2_q)           state_d = ST_DRAIN;
      ST_DRAIN: if (ack2_q == '0)    state_d = ST_OFF;
      default:                       state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign ready_o  = (state_q == ST_RUN);
  assign osc_en_o = (state_q != ST_OFF);
  assign pll_en_o = (state_q != ST_OFF);

  // R6
  warm_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WARM) |-> (cnt_q < CNT_W'(STAB_CYC)));

  // R6
  ready_after_warm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(osc_en_o) && $past(pll_en_o));
endmodule

// File: rtl/pwrdn_clk_seq.sv
module pwrdn_clk_seq #(
  parameter int NUM_GRP    = 4,
  parameter int CPU_GRP    = 0,
  parameter int STAB_CYC   = 43000,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               rst_ni,
  input  logic               cpu_clk_i,
  input  logic               tb_clk_i,
  input  logic               pwrdn_ni,
  input  logic [NUM_GRP-1:0] grp_clk_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  output logic [NUM_GRP-1:0] grp_clk_o,
  output logic               osc_en_o,
  output logic               pll_en_o,
  output logic               ready_o
);
  logic               sleep, run_cpu, fsm_run;
  logic [NUM_GRP-1:0] gate_on;

  pwrdn_req_qual i_qual (
    .clk_i     (cpu_clk_i),
    .rst_ni    (rst_ni),
    .req_ni    (pwrdn_ni),
    .fsm_run_i (fsm_run),
    .sleep_o   (sleep),
    .run_o     (run_cpu)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_gate
    pwrdn_clk_gate #(
      .ASYNC_RUN  (g != CPU_GRP),
      .SYNC_DEPTH (SYNC_DEPTH)
    ) i_gate (
      .clk_i  (grp_clk_i[g]),
      .rst_ni (rst_ni),
      .run_i  (run_cpu),
      .en_i   (grp_en_i[g]),
      .clk_o  (grp_clk_o[g]),
      .on_o   (gate_on[g])
    );
  end

  pwrdn_seq_fsm #(
    .NUM_GRP  (NUM_GRP),
    .STAB_CYC (STAB_CYC)
  ) i_fsm (
    .clk_i     (tb_clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep),
    .gate_on_i (gate_on),
    .run_o     (fsm_run),
    .osc_en_o  (osc_en_o),
    .pll_en_o  (pll_en_o),
    .ready_o   (ready_o)
  );

  // R5
  enables_after_stop_chk: assert property (@(posedge tb_clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (gate_on == '0));
endmodule

// File: tb/test_pwrdn_clk_seq.sv
module test_pwrdn_clk_seq;
  localparam int NG   = 4;
  localparam int STAB = 25;
  localparam int HALF [NG] = '{5, 15, 35, 11};
  // {grp_en_i, expected toggling mask}
  localparam logic [7:0] VEC [5] = '{8'hFF, 8'h55, 8'hAA, 8'h11, 8'h88};

  logic          rst_n = 1'b0, tb_clk = 1'b0, pwrdn_n = 1'b1;
  logic [NG-1:0] gclk = '0, grp_en = '1, grp_clk_o;
  logic          osc_en, pll_en, ready;

  always #4ns tb_clk = ~tb_clk;
  always #5ns gclk[0] = ~gclk[0];
  always #15ns gclk[1] = ~gclk[1];
  always #35ns gclk[2] = ~gclk[2];
  always #11ns gclk[3] = ~gclk[3];

  pwrdn_clk_seq #(.NUM_GRP(NG), .CPU_GRP(0), .STAB_CYC(STAB), .SYNC_DEPTH(2)) i_pwrdn_clk_seq (
    .rst_ni (rst_n), .cpu_clk_i (gclk[0]), .tb_clk_i (tb_clk), .pwrdn_ni (pwrdn_n),
    .grp_clk_i (gclk), .grp_en_i (grp_en), .grp_clk_o (grp_clk_o),
    .osc_en_o (osc_en), .pll_en_o (pll_en), .ready_o (ready)
  );

  int checks = 0, failures = 0;
  int rises [NG];
  int shorts [NG];
  realtime t_rise [NG];
  logic [NG-1:0] prev_o = '0;
  int ready_rises = 0;
  realtime t_ready_fall = 0;

  initial for (int g = 0; g < NG; g++) begin rises[g] = 0; shorts[g] = 0; t_rise[g] = 0; end

  always @(grp_clk_o) begin
    for (int g = 0; g < NG; g++) begin
      if (grp_clk_o[g] && !prev_o[g]) begin rises[g]++; t_rise[g] = $realtime; end
      if (!grp_clk_o[g] && prev_o[g])
        if (($realtime - t_rise[g]) / 1.0ns < real'(HALF[g]) - 0.01) shorts[g]++;
    end
    prev_o = grp_clk_o;
  end
  always @(posedge ready) ready_rises++;
  always @(negedge ready) t_ready_fall = $realtime;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap(output int s [NG]);
    for (int g = 0; g < NG; g++) s[g] = rises[g];
  endtask

  task automatic wake_and_time(input string req);
    int s [NG];
    realtime t0;
    int n;
    @(posedge osc_en); t0 = $realtime; snap(s);
    chk(pll_en == 1'b1, req, int'(pll_en), 1);
    @(posedge ready);
    n = int'(($realtime - t0) / 8.0ns);
    chk(n == STAB, req, n, STAB);
    for (int g = 0; g < NG; g++) chk(rises[g] == s[g], req, rises[g] - s[g], 0);
  endtask

  initial begin
    int s [NG];
    int base0, rr;
    realtime t_osc;
    #103ns;
    // R8 reset state
    chk(grp_clk_o == '0, "R8", int'(grp_clk_o), 0);
    chk(osc_en == 1'b0, "R8", int'(osc_en), 0);
    chk(pll_en == 1'b0, "R8", int'(pll_en), 0);
    chk(ready == 1'b0, "R8", int'(ready), 0);
    rst_n = 1'b1;
    // R6 first wake
    wake_and_time("R6");

    // R7 enable mask table
    foreach (VEC[i]) begin
      grp_en = VEC[i][7:4];
      #403ns; snap(s); #703ns;
      for (int g = 0; g < NG; g++)
        chk((rises[g] != s[g]) == VEC[i][g], "R7", rises[g] - s[g], int'(VEC[i][g]));
    end
    grp_en = '1;
    #403ns;

    // R1 one-cycle glitch ignored
    snap(s);
    @(negedge gclk[0]); #1ns pwrdn_n = 1'b0;
    @(negedge gclk[0]); #1ns pwrdn_n = 1'b1;
    #503ns;
    chk(ready == 1'b1, "R1", int'(ready), 1);
    chk(osc_en == 1'b1, "R1", int'(osc_en), 1);
    for (int g = 0; g < NG; g++) chk(rises[g] > s[g], "R1", rises[g] - s[g], 1);

    // R2 R3 R4 R5 power down
    for (int g = 0; g < NG; g++) shorts[g] = 0;
    @(negedge gclk[0]); #1ns;
    base0 = rises[0];
    pwrdn_n = 1'b0;
    @(negedge osc_en); t_osc = $realtime;
    chk(grp_clk_o == '0, "R5", int'(grp_clk_o), 0);
    chk(pll_en == 1'b0, "R5", int'(pll_en), 0);
    chk(t_ready_fall < t_osc, "R5", int'(t_ready_fall / 1.0ns), int'(t_osc / 1.0ns));
    chk(rises[0] - base0 == 4, "R2", rises[0] - base0, 4);
    snap(s); #1003ns;
    for (int g = 0; g < NG; g++) chk(rises[g] == s[g], "R4", rises[g] - s[g], 0);
    chk(grp_clk_o == '0, "R4", int'(grp_clk_o), 0);
    for (int g = 0; g < NG; g++) chk(shorts[g] == 0, "R3", shorts[g], 0);

    // R6 wake after sleep
    pwrdn_n = 1'b1;
    wake_and_time("R6");
    snap(s); #603ns;
    for (int g = 0; g < NG; g++) chk(rises[g] > s[g], "R6", rises[g] - s[g], 1);

    // R9 abort during settling
    pwrdn_n = 1'b0;
    @(negedge osc_en); #203ns;
    pwrdn_n = 1'b1;
    @(posedge osc_en); snap(s); rr = ready_rises;
    repeat (5) @(posedge tb_clk);
    #1ns pwrdn_n = 1'b0;
    @(negedge osc_en); #1ns;
    chk(ready_rises == rr, "R9", ready_rises - rr, 0);
    chk(pll_en == 1'b0, "R9", int'(pll_en), 0);
    for (int g = 0; g < NG; g++) chk(rises[g] == s[g], "R9", rises[g] - s[g], 0);
    #203ns;
    pwrdn_n = 1'b1;
    wake_and_time("R9");
    for (int g = 0; g < NG; g++) chk(shorts[g] == 0, "R3", shorts[g], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #900us;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule